// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire PHY management bus from a pair of software-visible registers. Software first loads a data word and then writes a command word. The command word names the PHY port and the register or device, chooses between the short-address (Clause 22) and extended-address (Clause 45) protocols, and gives the direction. The block then generates the management clock and shifts the complete frame out on a tri-state data pin. For a read, it captures the returned bits into the low half of the data word.

For an extended-address access, one software command produces two frames back to back. The first is an address frame that carries the 16-bit register number from the upper half of the data word. The second is the read or write frame itself. A clock-range field in the command word sets the management clock divider, so the bus clock stays within the standard limit across the range of core clock frequencies. A command written with its start bit clear does not start a transaction. It sends a single lone clock pulse, because some PHYs need one clock edge before they leave reset.

Top module: `mdio_master`

## Requirements
- R1: After reset both registers read zero, `mdc` is low and `mdio_oe` is low.
- R2: Writing the command register (`csr_addr`=0) with bit 0 set launches a transaction, and bit 0 reads back as 1 until the transaction ends. It reads 1 for exactly 128·H core cycles for a short-address access and 256·H cycles for an extended-address one, where H is the half period from R7.
- R3: Command word fields are: bit 1 set selects extended addressing; bits 3:2 give the direction, where 11 means read and any other value means write; bits 10:8 give the clock range; bits 20:16 give the register/device number; bits 25:21 give the port address. A short-address frame is 64 bits sent MSB first: 32 ones, start 01, opcode 01 (write) or 10 (read), port address, register number, turnaround 10, and 16 data bits taken from data bits 15:0.
- R4: An extended-address command sends an address frame first: start 00, opcode 00, port, device, turnaround 10, and data bits 31:16. It then sends an access frame: start 00, opcode 01 (write) or 11 (read), with the same port and device and with data bits 15:0.
- R5: In a read frame the master drives MDIO for the first 46 bit times and releases it (`mdio_oe` low) for the last 18. It samples `mdio_i` on each rising `mdc` of the 16 data bits, MSB first. After completion, data bits 15:0 hold the returned value and bits 31:16 are unchanged.
- R6: `mdio_o` changes only in the core cycle in which `mdc` falls.
- R7: The clock-range code k = 0..7 makes `mdc` high and low for H core cycles each, with H = 8, 13, 21, 31, 51, 62, 102, 162 respectively.
- R8: Writing the command register with bit 0 clear produces exactly one `mdc` pulse, high for H cycles. During this pulse `mdio_oe` stays low and bit 0 stays 0.
- R9: While a transaction or a lone pulse is in progress, writes to either register are ignored. After a write transaction, the data word still holds what it held before the transaction, and the command word reads back as issued with bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (CSR) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 1 | Register select: 0 command, 1 data |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest condition to reach from the ports is a register write that lands in the middle of a running transaction. To reach it, the bench polls the busy bit while counting cycles, and injects writes to both registers a fixed number of cycles after launch. It then shows that the frame on the wire, the frame length and both register contents are the same as without the injection. The second hard point is the seam between the two frames of an extended access. The bench captures every bit on the rising edge of `mdc` across both frames and checks that the clock keeps its period through the join.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int CR_W       = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_TICK, ST_ADDR, ST_XFER} seq_t;

  // Half period of the management clock, in core cycles, per clock-range code
  function automatic logic [7:0] mdc_half(input logic [CR_W-1:0] code);
    case (code)
      3'd0: mdc_half = 8'd8;
      3'd1: mdc_half = 8'd13;
      3'd2: mdc_half = 8'd21;
      3'd3: mdc_half = 8'd31;
      3'd4: mdc_half = 8'd51;
      3'd5: mdc_half = 8'd62;
      3'd6: mdc_half = 8'd102;
      default: mdc_half = 8'd162;
    endcase
  endfunction

  // Full management frame, first bit on the wire in the MSB
  function automatic logic [FRAME_BITS-1:0] make_frame(
      input logic c45, input logic [1:0] opc, input logic [4:0] port,
      input logic [4:0] regdev, input logic [15:0] payload);
    make_frame = {32'hFFFF_FFFF, 1'b0, ~c45, opc, port, regdev, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             mdc_q;
  logic             wrap;

  assign wrap = run && (cnt == half - 1'b1);
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: with no activity the clock rests low
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx #(
  parameter int FW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] frame,
  input  logic          rd_frame,
  input  logic          rise,
  input  logic          fall,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          done,
  output logic [15:0]   rdata
);
  localparam int IW       = $clog2(FW);
  localparam int TA_POS   = FW - 18;
  localparam int DATA_POS = FW - 16;

  logic [FW-1:0] sh;
  logic [IW-1:0] bidx;
  logic          act;
  logic          rd_q;
  logic [15:0]   rsh;
  logic          last;

  assign last    = (bidx == IW'(FW - 1));
  assign done    = act && fall && last;
  assign mdio_o  = act ? sh[FW-1] : 1'b1;
  assign mdio_oe = act && !(rd_q && (bidx >= IW'(TA_POS)));
  assign rdata   = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      bidx <= '0;
      act  <= 1'b0;
      rd_q <= 1'b0;
      rsh  <= '0;
    end else if (start) begin
      sh   <= frame;
      bidx <= '0;
      act  <= 1'b1;
      rd_q <= rd_frame;
    end else if (act) begin
      if (rise && rd_q && (bidx >= IW'(DATA_POS)))
        rsh <= {rsh[14:0], mdio_i};
      if (fall) begin
        if (last) begin
          act <= 1'b0;
        end else begin
          bidx <= bidx + 1'b1;
          sh   <= {sh[FW-2:0], 1'b1};
        end
      end
    end
  end

  // R5: the pin is released only inside a read frame
  p_release_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !mdio_oe) |-> rd_q);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic        csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FW    = FRAME_BITS;
  localparam int CR_LO = 8;
  localparam int RA_LO = 16;
  localparam int PA_LO = 21;

  seq_t        state;
  logic [31:0] ctl_q;
  logic [31:0] dat_q;

  logic             active, launch, go_busy, first_addr;
  logic             cmd_c45, cmd_rd;
  logic [4:0]       cmd_pa, cmd_ra;
  logic [1:0]       acc_op;
  logic [DIV_W-1:0] half_w;
  logic             mdc_rise, mdc_fall;
  logic             tx_start, tx_rd, tx_done;
  logic [FW-1:0]    tx_frame;
  logic [15:0]      rx_data;

  assign active  = (state != ST_IDLE);
  assign launch  = csr_we && !csr_addr && !active;
  assign go_busy = launch && csr_wdata[0];

  // Command fields come from the incoming word in the launch cycle
  assign cmd_c45 = launch ? csr_wdata[1] : ctl_q[1];
  assign cmd_rd  = launch ? (csr_wdata[3:2] == 2'b11) : (ctl_q[3:2] == 2'b11);
  assign cmd_pa  = launch ? csr_wdata[PA_LO +: 5] : ctl_q[PA_LO +: 5];
  assign cmd_ra  = launch ? csr_wdata[RA_LO +: 5] : ctl_q[RA_LO +: 5];
  assign acc_op  = cmd_c45 ? (cmd_rd ? 2'b11 : 2'b01) : (cmd_rd ? 2'b10 : 2'b01);

  assign first_addr = go_busy && cmd_c45;
  assign tx_start   = go_busy || (state == ST_ADDR && tx_done);
  assign tx_rd      = first_addr ? 1'b0 : cmd_rd;
  assign tx_frame   = first_addr
                    ? make_frame(1'b1, 2'b00, cmd_pa, cmd_ra, dat_q[31:16])
                    : make_frame(cmd_c45, acc_op, cmd_pa, cmd_ra, dat_q[15:0]);

  assign half_w    = DIV_W'(mdc_half(ctl_q[CR_LO +: CR_W]));
  assign csr_rdata = csr_addr ? dat_q : ctl_q;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active),
    .half (half_w),
    .mdc  (mdc),
    .rise (mdc_rise),
    .fall (mdc_fall)
  );

  mdio_frame_tx #(.FW(FW)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tx_start),
    .frame   (tx_frame),
    .rd_frame(tx_rd),
    .rise    (mdc_rise),
    .fall    (mdc_fall),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (tx_done),
    .rdata   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctl_q <= '0;
      dat_q <= '0;
    end else begin
      if (csr_we && csr_addr && !active)
        dat_q <= csr_wdata;
      unique case (state)
        ST_IDLE: if (launch) begin
          ctl_q <= csr_wdata;
          if (csr_wdata[0]) state <= csr_wdata[1] ? ST_ADDR : ST_XFER;
          else              state <= ST_TICK;
        end
        ST_TICK: if (mdc_fall) state <= ST_IDLE;
        ST_ADDR: if (tx_done) state <= ST_XFER;
        ST_XFER: if (tx_done) begin
          state    <= ST_IDLE;
          ctl_q[0] <= 1'b0;
          if (cmd_rd) dat_q[15:0] <= rx_data;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: data pin moves only together with a falling management clock
  p_mdio_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_o != $past(mdio_o)) |-> (!mdc && $past(mdc)));

  // R2: busy cannot drop without the access frame finishing
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !tx_done) |=> ctl_q[0]);

  // R2: busy implies a frame sequence is running
  p_busy_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |-> (state == ST_ADDR || state == ST_XFER));

  // R8: the pin is never driven outside a frame, the lone pulse included
  p_oe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (state == ST_ADDR || state == ST_XFER));

  // R9: writes during activity leave the stored fields alone
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && csr_we) |=> ($stable(ctl_q[31:1]) && $stable(dat_q[31:16])));

endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic        csr_addr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Responder / capture: one entry per rising mdc
  logic cap   [0:4095];
  logic capoe [0:4095];
  int   k  = 0;
  int   k0 = 0;
  logic [15:0] rsp = '0;
  int   pos;

  always @(posedge mdc) begin
    cap[k % 4096]   = mdio_o;
    capoe[k % 4096] = mdio_oe;
    k = k + 1;
  end

  always_comb begin
    pos    = (k - k0) % 64;
    mdio_i = (pos >= 48) ? rsp[63 - pos] : 1'b1;
  end

  // Pin-change rule monitor
  int   viol = 0;
  logic prev_o = 1'b1, prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (mdio_o !== prev_o) && !(mdc == 1'b0 && prev_mdc == 1'b1))
      viol = viol + 1;
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  function automatic int half_of(input int code);
    int div;
    case (code)
      0: div = 16;  1: div = 26;  2: div = 42;  3: div = 62;
      4: div = 102; 5: div = 124; 6: div = 204; default: div = 324;
    endcase
    return div / 2;
  endfunction

  function automatic logic [63:0] ref_frame(input bit c45, input bit addr_ph,
      input bit rd, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pay);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (addr_ph)   op = 2'b00;
    else if (!c45) op = rd ? 2'b10 : 2'b01;
    else           op = rd ? 2'b11 : 2'b01;
    return {{32{1'b1}}, st, op, pa, ra, 2'b10, pay};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_addr = 1'b0;
  endtask

  task automatic rd_reg(input bit a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
    csr_addr = 1'b0;
  endtask

  // R7 / R8: lone pulse for one clock-range code
  task automatic lone_pulse(input int code);
    int highs, k_start, oe_seen, busy_seen, h;
    h = half_of(code);
    k_start = k; highs = 0; oe_seen = 0; busy_seen = 0;
    wr(1'b0, 32'(code) << 8);
    for (int i = 0; i < 2 * h + 20; i++) begin
      #1;
      if (mdc) highs++;
      if (mdio_oe) oe_seen++;
      if (csr_rdata[0]) busy_seen++;
      @(negedge clk);
    end
    chk(highs == h, "R7", "mdc high time", 64'(highs), 64'(h));
    chk((k - k_start) == 1 && oe_seen == 0 && busy_seen == 0, "R8",
        "single pulse rises/oe/busy", 64'((k - k_start) * 256 + oe_seen + busy_seen), 64'd1 * 256);
  endtask

  // R2..R6, R9: one complete transaction
  task automatic txn(input bit c45, input bit rd, input logic [4:0] pa,
                     input logic [4:0] ra, input int code, input logic [15:0] hi,
                     input logic [15:0] lo, input bit inject);
    logic [31:0] ctl, dat_rb, ctl_rb, dat_exp;
    logic [63:0] got, exp, oe_got, oe_exp, mask;
    int cyc, v0, nfr, h;
    h   = half_of(code);
    nfr = c45 ? 2 : 1;
    rsp = ~lo ^ 16'h3C5A;
    ctl = (32'(pa) << 21) | (32'(ra) << 16) | (32'(code) << 8) |
          ((rd ? 32'd3 : 32'd1) << 2) | (32'(c45) << 1) | 32'd1;
    wr(1'b1, {hi, lo});
    k0 = k; v0 = viol;
    wr(1'b0, ctl);
    #1;
    cyc = 0;
    forever begin
      if (!csr_addr && !csr_rdata[0]) break;
      cyc++;
      if (cyc > 150000) break;
      if (inject && cyc == 100) begin csr_we = 1'b1; csr_addr = 1'b1; csr_wdata = 32'hDEADBEEF; end
      if (inject && cyc == 101) begin csr_addr = 1'b0; csr_wdata = 32'hFFFF_FFFE; end
      if (inject && cyc == 102) csr_we = 1'b0;
      @(negedge clk); #1;
    end
    chk(cyc == nfr * 128 * h, "R2", "busy length", 64'(cyc), 64'(nfr * 128 * h));
    chk((k - k0) == nfr * 64, "R2", "mdc rises per command", 64'(k - k0), 64'(nfr * 64));
    for (int f = 0; f < nfr; f++) begin
      bit aph, rdf;
      aph = c45 && (f == 0);
      rdf = rd && !aph;
      exp = ref_frame(c45, aph, rd, pa, ra, aph ? hi : lo);
      for (int i = 0; i < 64; i++) begin
        got[63 - i]    = cap[(k0 + f * 64 + i) % 4096];
        oe_got[63 - i] = capoe[(k0 + f * 64 + i) % 4096];
      end
      oe_exp = rdf ? {{46{1'b1}}, 18'd0} : '1;
      mask   = oe_exp;
      if (aph) chk((got & mask) == (exp & mask), "R4", "address frame", got, exp);
      else if (c45) chk((got & mask) == (exp & mask), "R4", "access frame", got, exp);
      else chk((got & mask) == (exp & mask), "R3", "short frame", got, exp);
      chk(oe_got == oe_exp, "R5", "drive enable pattern", oe_got, oe_exp);
    end
    chk(viol == v0, "R6", "pin change off falling edge", 64'(viol - v0), 64'd0);
    rd_reg(1'b1, dat_rb);
    rd_reg(1'b0, ctl_rb);
    dat_exp = {hi, rd ? rsp : lo};
    chk(dat_rb == dat_exp, inject ? "R9" : "R5", "data register", 64'(dat_rb), 64'(dat_exp));
    chk(ctl_rb == (ctl & ~32'd1), inject ? "R9" : "R2", "command readback",
        64'(ctl_rb), 64'(ctl & ~32'd1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_reg(1'b0, r); chk(r == 32'd0, "R1", "command reg", 64'(r), 64'd0);
    rd_reg(1'b1, r); chk(r == 32'd0, "R1", "data reg", 64'(r), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins", {62'd0, mdc, mdio_oe}, 64'd0);

    // R7, R8: sweep every clock-range code with a lone pulse
    for (int c = 0; c < 8; c++) lone_pulse(c);

    // R3, R5: short-address sweep over ports and registers
    for (int i = 0; i < 8; i++) begin
      logic [4:0] pa, ra;
      pa = 5'(i * 9 + 1);
      ra = 5'(31 - i * 5);
      txn(1'b0, i[0], pa, ra, 0, 16'(16'h1357 * i), 16'(16'hA0F1 + i * 16'h1111), 1'b0);
    end
    txn(1'b0, 1'b0, 5'd31, 5'd0, 0, 16'hBEEF, 16'h0000, 1'b0);
    txn(1'b0, 1'b1, 5'd0, 5'd31, 0, 16'hFFFF, 16'hFFFF, 1'b0);

    // R4: extended-address write and read
    txn(1'b1, 1'b0, 5'd3, 5'd7, 0, 16'h8001, 16'h5AA5, 1'b0);
    txn(1'b1, 1'b1, 5'd22, 5'd30, 0, 16'h7FFE, 16'h0F0F, 1'b0);

    // R2, R7: length at a slower clock range
    txn(1'b0, 1'b1, 5'd9, 5'd4, 2, 16'h1234, 16'h4321, 1'b0);

    // R9: register writes while a transaction runs (write and read)
    txn(1'b0, 1'b0, 5'd12, 5'd6, 0, 16'hC0DE, 16'h6A6A, 1'b1);
    txn(1'b1, 1'b1, 5'd17, 5'd2, 0, 16'h2468, 16'h1359, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule